// File: doc/BRIEF.md
# Load-Address Stride Prefetcher

This block watches the stream of load operations that a core executes. Each observation carries the instruction pointer of the load and the address it read. The block keeps a small table, indexed by the low bits of the instruction pointer. Each table entry remembers, for one load instruction, the address it touched last, the distance between its last two addresses, and how often that distance has recurred.

Once a load has shown the same non-zero distance several times in a row, every further matching access produces a prefetch request. The request asks for the current address plus that distance, and it is meant to warm the first-level data cache. Requests leave through a single valid/ready slot. If the consumer stalls, a newer request replaces the one that is waiting. A request whose target would land in a different 4 KB page from the triggering access is dropped.

Top module: `ip_stride_pf`

## Requirements
- R1: After reset `pf_valid` is low, and the first observation of any load never produces a request.
- R2: An observation whose instruction pointer upper bits (tag) differ from the stored tag of the selected entry, or that selects an empty entry, reinitialises the entry: last address becomes the observed address, distance zero, confidence zero, and no request is made.
- R3: Confidence is a 2-bit count. On a tracked load the distance is the observed address minus the stored last address. A distance equal to the stored one raises confidence, saturating at 3. From a fresh entry with a steady non-zero distance s, the first request follows the fourth access and targets that access's address plus s. It appears on `pf_addr` with `pf_valid` high in the cycle after the observation is sampled.
- R4: While the distance keeps matching with confidence at 2 or more, every observation produces a request for address plus distance.
- R5: A distance that does not match lowers confidence by one (floor 0) and makes no request. The stored distance is replaced by the new one only when confidence was already 0.
- R6: Loads that select different entries train independently when interleaved.
- R7: A distance of zero never produces a request.
- R8: A request whose target differs from the triggering address in any bit above bit 11 is suppressed.
- R9: While `pf_ready` is low, a pending request holds `pf_addr` stable, and a newer request overwrites it.
- R10: A request is removed when `pf_valid` and `pf_ready` are both high at a clock edge and no newer one arrives.
- R11: The entry index is the low `IDX_W` bits of the instruction pointer. Two loads that share those bits but differ above them evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obs_valid | input | 1 | A load observation is present this cycle |
| obs_ip | input | IP_W | Instruction pointer of the load |
| obs_addr | input | ADDR_W | Address read by the load |
| pf_ready | input | 1 | Consumer accepts the pending request |
| pf_valid | output | 1 | A prefetch request is pending |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The bench drives the confidence counter through its whole range. It checks that the first request comes exactly on the fourth steady access: a design that skipped the conf-0 capture step would fire one access early, and one that demanded saturation would fire one access late. It also makes a single outlier access at high confidence and then resumes the old distance, which exposes a design that overwrites the learned distance at every mismatch. Aliasing loads, a zero-distance load, a walk across a page boundary, and a stalled consumer that receives two requests in turn cover eviction, the zero and page filters, and the overwrite-newest rule.

// File: rtl/ipsp_pkg.sv
// Shared confidence type and saturating helpers for the stride prefetcher.
// Assumes a 2-bit confidence counter with a firing threshold of 2.
package ipsp_pkg;
    typedef logic [1:0] conf_t;
    localparam conf_t CONF_MAX  = 2'd3;
    localparam conf_t CONF_FIRE = 2'd2;

    function automatic conf_t conf_up(input conf_t c);
        return (c == CONF_MAX) ? c : c + 2'd1;
    endfunction

    function automatic conf_t conf_down(input conf_t c);
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction
endpackage

// File: rtl/ipsp_table.sv
// Direct-mapped per-load history table: one entry per index value.
// Assumes read and write use the same index in a cycle; the write is
// visible from the next cycle. Reset empties every entry.
module ipsp_table
    import ipsp_pkg::*;
#(
    parameter int TAG_W  = 28,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_last,
    input  logic [ADDR_W-1:0] wr_stride,
    input  conf_t             wr_conf,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_last,
    output logic [ADDR_W-1:0] rd_stride,
    output conf_t             rd_conf
);
    localparam int DEPTH = 1 << IDX_W;

    logic              e_valid  [DEPTH];
    logic [TAG_W-1:0]  e_tag    [DEPTH];
    logic [ADDR_W-1:0] e_last   [DEPTH];
    logic [ADDR_W-1:0] e_stride [DEPTH];
    conf_t             e_conf   [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Holds one entry; loads it when this index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid[e]  <= 1'b0;
                e_tag[e]    <= '0;
                e_last[e]   <= '0;
                e_stride[e] <= '0;
                e_conf[e]   <= '0;
            end else if (wr_en && idx == IDX_W'(e)) begin
                e_valid[e]  <= 1'b1;
                e_tag[e]    <= wr_tag;
                e_last[e]   <= wr_last;
                e_stride[e] <= wr_stride;
                e_conf[e]   <= wr_conf;
            end
        end
    end

    // Combinational read of the selected entry.
    always_comb begin
        rd_valid  = e_valid[idx];
        rd_tag    = e_tag[idx];
        rd_last   = e_last[idx];
        rd_stride = e_stride[idx];
        rd_conf   = e_conf[idx];
    end

    a_r1_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> e_valid[$past(idx)]);
endmodule

// File: rtl/ipsp_train.sv
// Training and decision logic: computes the updated entry for an
// observation and decides whether a prefetch is issued.
// Assumes the table entry read for the observation is already presented.
module ipsp_train
    import ipsp_pkg::*;
#(
    parameter int IP_W      = 32,
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 4,
    parameter int PAGE_BITS = 12,
    localparam int TAG_W    = IP_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_valid,
    input  logic [IP_W-1:0]   obs_ip,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [ADDR_W-1:0] rd_last,
    input  logic [ADDR_W-1:0] rd_stride,
    input  conf_t             rd_conf,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [ADDR_W-1:0] wr_last,
    output logic [ADDR_W-1:0] wr_stride,
    output conf_t             wr_conf,
    output logic              fire,
    output logic [ADDR_W-1:0] target
);
    logic              hit;
    logic              same;
    logic              page_ok;
    logic [ADDR_W-1:0] delta;

    // Splits the instruction pointer into index and tag.
    always_comb begin
        idx    = obs_ip[IDX_W-1:0];
        wr_tag = obs_ip[IP_W-1:IDX_W];
    end

    // Updates the entry fields and applies the request filters.
    always_comb begin
        hit       = obs_valid && rd_valid && (rd_tag == wr_tag);
        delta     = obs_addr - rd_last;
        same      = (delta == rd_stride);
        wr_en     = obs_valid;
        wr_last   = obs_addr;
        wr_stride = '0;
        wr_conf   = '0;
        if (hit) begin
            if (same) begin
                wr_stride = rd_stride;
                wr_conf   = conf_up(rd_conf);
            end else begin
                wr_stride = (rd_conf == 2'd0) ? delta : rd_stride;
                wr_conf   = conf_down(rd_conf);
            end
        end
        target  = obs_addr + rd_stride;
        page_ok = (target[ADDR_W-1:PAGE_BITS] == obs_addr[ADDR_W-1:PAGE_BITS]);
        fire    = hit && same && (rd_stride != '0) && (wr_conf >= CONF_FIRE) && page_ok;
    end

    a_r2_fire_needs_tracked_load: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> rd_valid && obs_valid);
    a_r7_no_zero_stride: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> target != obs_addr);
    a_r8_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ((target ^ obs_addr) >> PAGE_BITS) == '0);
    a_r3_conf_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> rd_conf >= 2'd1);
endmodule

// File: rtl/ipsp_slot.sv
// Single-entry output slot with valid/ready handshake.
// A new request always replaces a waiting one; acceptance clears it.
module ipsp_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    // Loads the newest request or drops the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else if (load) begin
            pf_valid <= 1'b1;
            pf_addr  <= load_addr;
        end else if (pf_valid && pf_ready) begin
            pf_valid <= 1'b0;
        end
    end

    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready && !load |=> pf_valid && $stable(pf_addr));
    a_r9_newest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pf_valid && pf_addr == $past(load_addr));
    a_r10_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready && !load |=> !pf_valid);
endmodule

// File: rtl/ip_stride_pf.sv
// Per-load stride prefetcher top: history table, training logic and
// output slot. Assumes at most one load observation per cycle.
module ip_stride_pf
    import ipsp_pkg::*;
#(
    parameter int IP_W      = 32,
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 4,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_valid,
    input  logic [IP_W-1:0]   obs_ip,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    localparam int TAG_W = IP_W - IDX_W;

    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [ADDR_W-1:0] wr_last;
    logic [ADDR_W-1:0] wr_stride;
    conf_t             wr_conf;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_last;
    logic [ADDR_W-1:0] rd_stride;
    conf_t             rd_conf;
    logic              fire;
    logic [ADDR_W-1:0] target;

    ipsp_table #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en),
        .wr_tag(wr_tag), .wr_last(wr_last), .wr_stride(wr_stride), .wr_conf(wr_conf),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_last(rd_last),
        .rd_stride(rd_stride), .rd_conf(rd_conf)
    );

    ipsp_train #(.IP_W(IP_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_BITS(PAGE_BITS)) u_train (
        .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_ip(obs_ip), .obs_addr(obs_addr),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_last(rd_last),
        .rd_stride(rd_stride), .rd_conf(rd_conf),
        .idx(idx), .wr_en(wr_en), .wr_tag(wr_tag), .wr_last(wr_last),
        .wr_stride(wr_stride), .wr_conf(wr_conf), .fire(fire), .target(target)
    );

    ipsp_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(fire), .load_addr(target),
        .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    a_r1_request_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_valid ##1 pf_valid |-> $past(obs_valid));
endmodule

// File: tb/ip_stride_pf_test.sv
// Directed bench: one task per scenario, each checking its own results.
module ip_stride_pf_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        obs_valid = 1'b0;
    logic [31:0] obs_ip = '0;
    logic [31:0] obs_addr = '0;
    logic        pf_ready = 1'b1;
    logic        pf_valid;
    logic [31:0] pf_addr;
    int          checks = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ip_stride_pf uut (
        .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_ip(obs_ip),
        .obs_addr(obs_addr), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    // Presents one observation for one cycle; returns at the following negedge.
    task automatic observe(input logic [31:0] ip, input logic [31:0] a);
        @(negedge clk);
        obs_valid = 1'b1; obs_ip = ip; obs_addr = a;
        @(negedge clk);
        obs_valid = 1'b0;
    endtask

    task automatic expect_pf(input string req, input logic ev, input logic [31:0] ea);
        checks++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            fails++;
            $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
                     req, pf_valid, pf_addr, ev, ea);
        end
    endtask

    task automatic t_reset;
        expect_pf("R1 reset", 1'b0, '0);
        observe(32'h0000_0105, 32'h2000_0000);
        expect_pf("R1 first observation", 1'b0, '0);
    endtask

    task automatic t_train;
        // R3: fire on the fourth access; R4: continue on every match
        observe(32'h0000_0011, 32'h3000_0000);
        observe(32'h0000_0011, 32'h3000_0040);
        expect_pf("R3 second access", 1'b0, '0);
        observe(32'h0000_0011, 32'h3000_0080);
        expect_pf("R3 third access", 1'b0, '0);
        observe(32'h0000_0011, 32'h3000_00C0);
        expect_pf("R3 fourth access fires", 1'b1, 32'h3000_0100);
        @(negedge clk);
        expect_pf("R10 accepted request cleared", 1'b0, '0);
        observe(32'h0000_0011, 32'h3000_0100);
        expect_pf("R4 continues", 1'b1, 32'h3000_0140);
    endtask

    task automatic t_mismatch;
        // R5: an outlier at conf 3 keeps the old stride
        observe(32'h0000_0022, 32'h4000_0000);
        observe(32'h0000_0022, 32'h4000_0020);
        observe(32'h0000_0022, 32'h4000_0040);
        observe(32'h0000_0022, 32'h4000_0060);
        observe(32'h0000_0022, 32'h4000_0080);
        expect_pf("R4 conf 3 fires", 1'b1, 32'h4000_00A0);
        observe(32'h0000_0022, 32'h4000_0087);
        expect_pf("R5 outlier no request", 1'b0, '0);
        observe(32'h0000_0022, 32'h4000_00A7);
        expect_pf("R5 old stride kept", 1'b1, 32'h4000_00C7);
        // R5: mismatch at conf 0 replaces the stride
        observe(32'h0000_0033, 32'h5000_0000);
        observe(32'h0000_0033, 32'h5000_0010);
        observe(32'h0000_0033, 32'h5000_0090);
        expect_pf("R5 replace at conf 0", 1'b0, '0);
        observe(32'h0000_0033, 32'h5000_0110);
        observe(32'h0000_0033, 32'h5000_0190);
        expect_pf("R5 new stride fires", 1'b1, 32'h5000_0210);
    endtask

    task automatic t_interleave;
        // R6: two entries trained in alternation
        for (int k = 0; k < 4; k++) begin
            observe(32'h0000_0304, 32'h6000_0000 + 32'(k) * 32'h100);
            if (k == 3) expect_pf("R6 first load", 1'b1, 32'h6000_0400);
            observe(32'h0000_0305, 32'h7000_1000 - 32'(k) * 32'h8);
            if (k == 3) expect_pf("R6 second load negative", 1'b1, 32'h7000_0FE0);
        end
    endtask

    task automatic t_alias;
        // R11/R2: same low 4 bits, different tag evicts
        for (int k = 0; k < 4; k++) observe(32'h0000_0106, 32'h1100_0000 + 32'(k) * 32'h4);
        expect_pf("R11 trained before eviction", 1'b1, 32'h1100_0010);
        observe(32'h0000_0206, 32'h1200_0000);
        expect_pf("R2 new tag no request", 1'b0, '0);
        observe(32'h0000_0106, 32'h1100_0010);
        expect_pf("R11 evicted load retrains", 1'b0, '0);
    endtask

    task automatic t_zero;
        // R7: repeated identical address
        for (int k = 0; k < 6; k++) begin
            observe(32'h0000_0047, 32'h8000_0500);
            if (k >= 3) expect_pf("R7 zero stride", 1'b0, '0);
        end
    endtask

    task automatic t_page;
        // R8: target in next page suppressed, next access in new page fires
        observe(32'h0000_0058, 32'h9000_0F00);
        observe(32'h0000_0058, 32'h9000_0F40);
        observe(32'h0000_0058, 32'h9000_0F80);
        observe(32'h0000_0058, 32'h9000_0FC0);
        expect_pf("R8 page cross suppressed", 1'b0, '0);
        observe(32'h0000_0058, 32'h9000_1000);
        expect_pf("R8 same page fires", 1'b1, 32'h9000_1040);
    endtask

    task automatic t_stall;
        // R9: hold and overwrite while stalled, R10: clear on accept
        pf_ready = 1'b0;
        for (int k = 0; k < 4; k++) observe(32'h0000_0069, 32'hA000_0000 + 32'(k) * 32'h10);
        expect_pf("R9 pending", 1'b1, 32'hA000_0040);
        @(negedge clk);
        @(negedge clk);
        expect_pf("R9 held stable", 1'b1, 32'hA000_0040);
        observe(32'h0000_0069, 32'hA000_0040);
        expect_pf("R9 newest overwrites", 1'b1, 32'hA000_0050);
        pf_ready = 1'b1;
        @(negedge clk);
        expect_pf("R10 cleared after accept", 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_train();
        t_mismatch();
        t_interleave();
        t_alias();
        t_zero();
        t_page();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule